// File: doc/BRIEF.md
# Interrupt Trap Injection Unit

This unit sits next to a four-stage in-order pipeline (fetch, decode, execute, writeback). It turns a pending interrupt request into a trap pseudo-instruction placed in the decode slot. Request pulses from several sources are latched into sticky flags. A source is eligible when its enable is set and its programmable level is above the current CPU level. One arbitration round then picks a single winner.

In the cycle after arbitration, the unit replaces the decode-stage instruction with the trap. In that same cycle it discards the instruction in fetch, clears the winner's flag and captures the decode-stage address as the resume point. One cycle later it raises the context-save strobes and steers fetch to the winner's handler vector. The instruction that was in decode when arbitration ended, and everything older, completes normally. The two squashed instructions are fetched again after the handler returns.

With no stall, the first handler fetch comes three cycles after the flag becomes visible. A decode stall holds the injection cycle, so it stretches that delay.

Top module: `irq_trap_inject`

## Requirements
- R1: A high bit of `irq_set_i` sampled at a clock edge makes the matching bit of `irq_pend_o` high after that edge. The bit stays high until that source's trap is injected.
- R2: A pending source takes part in arbitration only if its `irq_en_i` bit is 1 and its level is strictly greater than `cpu_lvl_i`. A level equal to the CPU level is not eligible.
- R3: Among eligible sources, the one with the highest level wins. When levels are equal, the lowest source index wins. The winner appears on `trap_src_o`.
- R4: Timing without stall, with edge E0 being the edge that captures the request:
  - after E0 the unit is idle with the flag set;
  - after E1 it arbitrates, with `inject_o` still 0;
  - after E2 `inject_o` and `squash_o` are 1 for one cycle;
  - after E3 `redirect_o` is 1 for one cycle.
- R5: At the edge that ends an injection cycle, the winner's bit of `irq_pend_o` is cleared.
- R6: `resume_addr_o` takes the value of `dec_pc_i` sampled in the injection cycle, which is the address of the squashed decode instruction. It is valid while `redirect_o` is 1.
- R7: While `redirect_o` is 1, `save_psw_o` and `save_ip_o` are 1. `save_csp_o` is 1 only if `seg_mode_i` is also 1.
- R8: While `redirect_o` is 1, `redirect_addr_o` equals `VEC_BASE + 4*trap_src_o`. The default `VEC_BASE` is 0x0100.
- R9: While `stall_i` is 1 in the injection cycle, `inject_o` stays 0 and the winner's flag stays set. Injection happens in the first cycle with `stall_i` at 0, and the winner does not change.
- R10: A request that arrives during the injection or save cycle does not change the current winner. It is arbitrated in a later round. A set pulse for the winner in its own injection cycle leaves its flag set.
- R11: While `rst_ni` is low, all flags and all strobe outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_set_i | input | N_SRC | Per-source request pulse |
| irq_en_i | input | N_SRC | Per-source enable |
| irq_lvl_i | input | N_SRC*LVL_W | Per-source priority level; source i in bits [i*LVL_W +: LVL_W] |
| cpu_lvl_i | input | LVL_W | Current CPU priority level |
| stall_i | input | 1 | Decode cannot advance this cycle |
| seg_mode_i | input | 1 | Segmented mode; enables the code-segment save |
| dec_pc_i | input | ADDR_W | Address of the instruction in decode |
| irq_pend_o | output | N_SRC | Request flags |
| inject_o | output | 1 | Replace the decode instruction with the trap |
| squash_o | output | 1 | Discard the instruction in fetch |
| trap_src_o | output | $clog2(N_SRC) | Winning source index |
| save_psw_o | output | 1 | Save the status word |
| save_ip_o | output | 1 | Save the instruction pointer |
| save_csp_o | output | 1 | Save the code segment pointer |
| redirect_o | output | 1 | Fetch from `redirect_addr_o` |
| redirect_addr_o | output | ADDR_W | Handler vector address |
| resume_addr_o | output | ADDR_W | Return address (the squashed decode instruction) |

## Verification
The bench targets these corner cases:
- **Equal levels.** A design that ranked ties by the higher index would report the wrong `trap_src_o` and vector.
- **A level equal to the CPU level.** A design that compared with `>=` would inject a trap the CPU should still mask.
- **A stall in the injection cycle.** A design that cleared the flag or advanced anyway would lose the request or fire the trap into a frozen decode stage.
- **Requests during the injection window.** A late, higher-ranked source must not displace the winner already latched. A re-raised request on the winner's own clear cycle must survive, or an interrupt is silently dropped.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_INJ  = 2'd2,
    ST_SAVE = 2'd3
  } trap_st_e;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int N_SRC = 8,
  localparam int SW = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [SW-1:0]    clr_idx_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] clr_mask;

  assign clr_mask = clr_en_i ? (N_SRC'(1) << clr_idx_i) : '0;

  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_mask) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  localparam int SW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC-1:0]       en_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]       cpu_lvl_i,
  output logic                   any_o,
  output logic [SW-1:0]          win_o
);
  logic [N_SRC-1:0] elig;
  logic [LVL_W-1:0] lvl [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign lvl[g]  = lvl_i[g*LVL_W +: LVL_W];
    assign elig[g] = pend_i[g] & en_i[g] & (lvl[g] > cpu_lvl_i);
  end

  // strict '>' keeps the lower index on ties
  always_comb begin
    logic             found;
    logic [LVL_W-1:0] best;
    logic [SW-1:0]    idx;
    found = 1'b0;
    best  = '0;
    idx   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!found || lvl[i] > best)) begin
        found = 1'b1;
        best  = lvl[i];
        idx   = SW'(i);
      end
    end
    any_o = found;
    win_o = idx;
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_trap_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0100,
  localparam int SW = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [SW-1:0]     win_i,
  input  logic              stall_i,
  input  logic              seg_mode_i,
  input  logic [ADDR_W-1:0] dec_pc_i,
  output logic              inject_o,
  output logic              squash_o,
  output logic [SW-1:0]     trap_src_o,
  output logic              save_psw_o,
  output logic              save_ip_o,
  output logic              save_csp_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic [ADDR_W-1:0] resume_addr_o
);
  trap_st_e          st_q, st_d;
  logic [SW-1:0]     win_q;
  logic [ADDR_W-1:0] resume_q;
  logic              fire;

  assign fire = (st_q == ST_INJ) && !stall_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (any_i) st_d = ST_ARB;
      ST_ARB:  st_d = any_i ? ST_INJ : ST_IDLE;
      ST_INJ:  if (!stall_i) st_d = ST_SAVE;
      ST_SAVE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      win_q    <= '0;
      resume_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ARB && any_i) win_q <= win_i;
      if (fire) resume_q <= dec_pc_i;
    end
  end

  assign inject_o        = fire;
  assign squash_o        = fire;
  assign trap_src_o      = win_q;
  assign save_psw_o      = (st_q == ST_SAVE);
  assign save_ip_o       = (st_q == ST_SAVE);
  assign save_csp_o      = (st_q == ST_SAVE) && seg_mode_i;
  assign redirect_o      = (st_q == ST_SAVE);
  assign redirect_addr_o = VEC_BASE + (ADDR_W'(win_q) << 2);
  assign resume_addr_o   = resume_q;
endmodule

// File: rtl/irq_trap_inject.sv
module irq_trap_inject #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0100,
  localparam int SW = $clog2(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       irq_set_i,
  input  logic [N_SRC-1:0]       irq_en_i,
  input  logic [N_SRC*LVL_W-1:0] irq_lvl_i,
  input  logic [LVL_W-1:0]       cpu_lvl_i,
  input  logic                   stall_i,
  input  logic                   seg_mode_i,
  input  logic [ADDR_W-1:0]      dec_pc_i,
  output logic [N_SRC-1:0]       irq_pend_o,
  output logic                   inject_o,
  output logic                   squash_o,
  output logic [SW-1:0]          trap_src_o,
  output logic                   save_psw_o,
  output logic                   save_ip_o,
  output logic                   save_csp_o,
  output logic                   redirect_o,
  output logic [ADDR_W-1:0]      redirect_addr_o,
  output logic [ADDR_W-1:0]      resume_addr_o
);
  logic          any;
  logic [SW-1:0] win;
  logic          inj;
  logic [SW-1:0] src;

  irq_flags #(.N_SRC(N_SRC)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (irq_set_i),
    .clr_en_i  (inj),
    .clr_idx_i (src),
    .pend_o    (irq_pend_o)
  );

  irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .pend_i    (irq_pend_o),
    .en_i      (irq_en_i),
    .lvl_i     (irq_lvl_i),
    .cpu_lvl_i (cpu_lvl_i),
    .any_o     (any),
    .win_o     (win)
  );

  irq_seq #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .any_i           (any),
    .win_i           (win),
    .stall_i         (stall_i),
    .seg_mode_i      (seg_mode_i),
    .dec_pc_i        (dec_pc_i),
    .inject_o        (inj),
    .squash_o        (squash_o),
    .trap_src_o      (src),
    .save_psw_o      (save_psw_o),
    .save_ip_o       (save_ip_o),
    .save_csp_o      (save_csp_o),
    .redirect_o      (redirect_o),
    .redirect_addr_o (redirect_addr_o),
    .resume_addr_o   (resume_addr_o)
  );

  assign inject_o   = inj;
  assign trap_src_o = src;
endmodule

// File: rtl/irq_trap_inject_chk.sv
module irq_trap_inject_chk #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0100,
  localparam int SW = $clog2(N_SRC)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_SRC-1:0]       irq_set_i,
  input logic [N_SRC-1:0]       irq_en_i,
  input logic [N_SRC*LVL_W-1:0] irq_lvl_i,
  input logic [LVL_W-1:0]       cpu_lvl_i,
  input logic                   stall_i,
  input logic                   seg_mode_i,
  input logic [ADDR_W-1:0]      dec_pc_i,
  input logic [N_SRC-1:0]       irq_pend_o,
  input logic                   inject_o,
  input logic                   squash_o,
  input logic [SW-1:0]          trap_src_o,
  input logic                   save_psw_o,
  input logic                   save_ip_o,
  input logic                   save_csp_o,
  input logic                   redirect_o,
  input logic [ADDR_W-1:0]      redirect_addr_o,
  input logic [ADDR_W-1:0]      resume_addr_o
);
  a_r1_flag_only_falls_on_inject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_pend_o) & ~irq_pend_o &
     ~($past(inject_o) ? (N_SRC'(1) << $past(trap_src_o)) : N_SRC'(0))) == '0);

  a_r4_redirect_follows_inject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |=> redirect_o);

  a_r4_redirect_needs_inject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(inject_o));

  a_r5_winner_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inject_o && !irq_set_i[trap_src_o]) |=> !irq_pend_o[$past(trap_src_o)]);

  a_r5_squash_with_inject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o == inject_o);

  a_r7_save_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (save_psw_o && save_ip_o));

  a_r7_csp_only_segmented: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_csp_o |-> (redirect_o && seg_mode_i));

  a_r8_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (redirect_addr_o == VEC_BASE + (ADDR_W'(trap_src_o) << 2)));

  a_r9_stall_blocks_inject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !inject_o);

  a_r10_winner_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $stable(trap_src_o));
endmodule

bind irq_trap_inject irq_trap_inject_chk #(
  .N_SRC(N_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
) u_chk (.*);

// File: tb/irq_trap_inject_tb.sv
module irq_trap_inject_tb;
  localparam int N = 8;
  localparam int PW = 4;
  localparam int AW = 16;
  localparam int SW = 3;
  localparam logic [AW-1:0] VB = 16'h0100;

  typedef struct packed {
    logic [N-1:0]    en;
    logic [N*PW-1:0] lvl;
    logic [PW-1:0]   cpu;
    logic [N-1:0]    set;
    logic            any;
    logic [SW-1:0]   src;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{8'hFF, 32'h55555555, 4'd2, 8'h08, 1'b1, 3'd3},  // R2 single eligible
    '{8'hFF, 32'h55555555, 4'd2, 8'h24, 1'b1, 3'd2},  // R3 tie -> lower index
    '{8'hFF, 32'h00900400, 4'd0, 8'h24, 1'b1, 3'd5},  // R3 higher level wins
    '{8'hFE, 32'h55555555, 4'd0, 8'h01, 1'b0, 3'd0},  // R2 disabled
    '{8'hFF, 32'h33333333, 4'd3, 8'h02, 1'b0, 3'd0},  // R2 level == cpu
    '{8'hFF, 32'h20000002, 4'd1, 8'h81, 1'b1, 3'd0},  // R3 tie at ends
    '{8'hFF, 32'h10000000, 4'd0, 8'h80, 1'b1, 3'd7}   // R8 top vector
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N-1:0]   irq_set_i = '0;
  logic [N-1:0]   irq_en_i = '0;
  logic [N*PW-1:0] irq_lvl_i = '0;
  logic [PW-1:0]  cpu_lvl_i = '0;
  logic           stall_i = 1'b0;
  logic           seg_mode_i = 1'b0;
  logic [AW-1:0]  dec_pc_i = '0;
  logic [N-1:0]   irq_pend_o;
  logic           inject_o, squash_o;
  logic [SW-1:0]  trap_src_o;
  logic           save_psw_o, save_ip_o, save_csp_o, redirect_o;
  logic [AW-1:0]  redirect_addr_o, resume_addr_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_trap_inject u_dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    irq_set_i = '0;
    stall_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic arm(input logic [N-1:0] set);
    irq_en_i = '1;
    irq_lvl_i = 32'h55555555;
    cpu_lvl_i = '0;
    irq_set_i = set;
    @(negedge clk_i);
    irq_set_i = '0;  // after E0
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    // R11 reset state
    @(negedge clk_i);
    chk(irq_pend_o == '0, "R11 flags", irq_pend_o, 0);
    chk({inject_o, squash_o, redirect_o, save_psw_o, save_ip_o, save_csp_o} == '0,
        "R11 strobes", {inject_o, redirect_o}, 0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [AW-1:0] pc;
      do_reset();
      pc = AW'(16'h2000 + k * 4);
      seg_mode_i = k[0];
      irq_en_i  = TBL[k].en;
      irq_lvl_i = TBL[k].lvl;
      cpu_lvl_i = TBL[k].cpu;
      irq_set_i = TBL[k].set;
      @(negedge clk_i);  // after E0
      irq_set_i = '0;
      chk(irq_pend_o == TBL[k].set, "R1 flag set", irq_pend_o, TBL[k].set);
      @(negedge clk_i);  // after E1
      chk(!inject_o, "R4 no inject in arbitration", inject_o, 0);
      dec_pc_i = pc;
      @(negedge clk_i);  // after E2
      chk(inject_o == TBL[k].any, "R2 inject", inject_o, TBL[k].any);
      if (TBL[k].any) begin
        chk(squash_o, "R5 squash", squash_o, 1);
        chk(trap_src_o == TBL[k].src, "R3 winner", trap_src_o, TBL[k].src);
      end
      @(negedge clk_i);  // after E3
      chk(redirect_o == TBL[k].any, "R4 redirect", redirect_o, TBL[k].any);
      if (TBL[k].any) begin
        chk(redirect_addr_o == VB + AW'(TBL[k].src) * 4, "R8 vector",
            redirect_addr_o, VB + AW'(TBL[k].src) * 4);
        chk(save_psw_o && save_ip_o, "R7 psw/ip", {save_psw_o, save_ip_o}, 2'b11);
        chk(save_csp_o == k[0], "R7 csp", save_csp_o, k[0]);
        chk(resume_addr_o == pc, "R6 resume", resume_addr_o, pc);
        chk(!irq_pend_o[TBL[k].src], "R5 flag cleared", irq_pend_o, 0);
      end else begin
        chk(irq_pend_o == TBL[k].set, "R2 ineligible stays pending", irq_pend_o, TBL[k].set);
      end
    end

    // R9 stall during injection
    do_reset();
    seg_mode_i = 1'b0;
    arm(8'h02);
    stall_i = 1'b1;
    @(negedge clk_i);  // after E1
    @(negedge clk_i);  // after E2, in inject state
    chk(!inject_o, "R9 stalled no inject", inject_o, 0);
    @(negedge clk_i);
    chk(!inject_o && !redirect_o, "R9 held", {inject_o, redirect_o}, 0);
    chk(irq_pend_o[1], "R9 flag kept", irq_pend_o, 8'h02);
    stall_i = 1'b0;
    dec_pc_i = 16'h3456;
    #1;
    chk(inject_o && trap_src_o == 3'd1, "R9 inject on release", {inject_o, trap_src_o}, 4'b1001);
    @(negedge clk_i);
    chk(redirect_o && resume_addr_o == 16'h3456, "R9 redirect after release",
        resume_addr_o, 16'h3456);
    chk(!irq_pend_o[1], "R5 flag cleared after stall", irq_pend_o, 0);

    // R10 late request does not displace winner
    do_reset();
    arm(8'h10);
    @(negedge clk_i);  // after E1
    @(negedge clk_i);  // after E2
    chk(inject_o && trap_src_o == 3'd4, "R10 first winner", trap_src_o, 4);
    irq_set_i = 8'h01;
    @(negedge clk_i);  // after E3
    irq_set_i = '0;
    chk(redirect_o && trap_src_o == 3'd4, "R10 winner kept", trap_src_o, 4);
    chk(irq_pend_o == 8'h01, "R10 late flag pending", irq_pend_o, 8'h01);
    @(negedge clk_i);
    chk(!inject_o, "R10 idle gap", inject_o, 0);
    @(negedge clk_i);
    chk(!inject_o, "R10 arbitration gap", inject_o, 0);
    @(negedge clk_i);
    chk(inject_o && trap_src_o == 3'd0, "R10 second round", trap_src_o, 0);

    // R10 re-raise on own clear cycle
    do_reset();
    arm(8'h40);
    @(negedge clk_i);
    @(negedge clk_i);  // inject cycle
    irq_set_i = 8'h40;
    @(negedge clk_i);
    irq_set_i = '0;
    chk(irq_pend_o[6], "R10 set beats clear", irq_pend_o, 8'h40);

    // R11 reset mid-sequence
    rst_ni = 1'b0;
    #1;
    chk(irq_pend_o == '0 && !redirect_o, "R11 async reset", irq_pend_o, 0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule